// File: doc/BRIEF.md
# Standby Save/Restore Sequencer

This block takes one logic power domain into a low-leakage standby and brings it back. A request arrives from software (an interrupt-driven request) or from an idle timeout. For a deep standby the sequencer asks the processor to save its context, asks for the caches and translation buffers to be flushed, stops the domain clocks, shifts the domain's register contents out through the scan chains to external non-volatile storage, and then opens the power switch. While the domain is off, only the external wake interrupt and the real-time-clock expiry are watched. A wake runs the same steps backwards: power returns, state is shifted back in, clocks restart, and the processor restores its context.

A second, lighter mode, freeze, keeps the domain powered at a reduced voltage with its clocks stopped. It does no save, flush or scan, so it resumes on the cycle after the wake. Every wait on an external done or power-good input is bounded by a programmable cycle limit, and an overrun parks the block in a sticky error state. A wake that arrives part-way through shutdown is held, so restore starts as soon as the domain reaches the off state. Two status outputs report the last mode entered and which source woke the domain.

Top module: `standby_seq`

## Requirements
- R1: While reset is held low and on the first cycle after it is released: busy, stby_ack, err, save_req, flush_req, restore_req, clk_stop, vlow and scan_stb are 0, pwr_en is 1, and last_mode and wake_src are 0.
- R2: When idle (busy = 0), a high sw_req or idle_expire starts a sequence. On the next cycle save_req is high if mode_freeze was 0, and vlow is high if it was 1. At that same start, last_mode takes the value of mode_freeze (0 = deep, 1 = freeze).
- R3: Deep shutdown keeps this order. save_req stays high until save_done. flush_req is high from the next cycle until flush_done. clk_stop rises on the cycle after flush_done, with no scan strobe yet.
- R4: scan_stb is high for exactly CHAIN_LEN consecutive cycles for the save and again for the restore. scan_dir is 0 during the save transfer and 1 during the restore transfer. pwr_en is always 1 while scan_stb is high.
- R5: After the save transfer, pwr_en drops and stays low until pwr_good is seen low. On the next cycle stby_ack goes high.
- R6: In deep standby only wake_irq or rtc_expire ends the wait, and sw_req has no effect. On the cycle after a wake, pwr_en is 1 and stby_ack is 0.
- R7: Restore keeps this order. The block waits for pwr_good, then runs the restore transfer. clk_stop is then low for one cycle with restore_req low. restore_req is then high until restore_done, and on the next cycle busy is 0.
- R8: Freeze keeps pwr_en at 1 and drives clk_stop and vlow at 1, with no save, flush or scan activity. One cycle after a wake, busy, clk_stop and vlow are all 0.
- R9: A wake seen during the shutdown steps is held and does not change the shutdown order. Power returns (pwr_en = 1) on the cycle after stby_ack first rises.
- R10: wake_src records the first wake event of a standby episode: 0 for wake_irq, 1 for rtc_expire, and 0 when both arrive in the same cycle. Wake inputs while idle leave wake_src unchanged.
- R11: In a wait state with limit L = wait_limit, a done seen on cycle 0..L of the state advances the sequence. Without one, err goes high after L+1 cycles in the state and stays high until reset, whatever the inputs do.
- R12: busy is high whenever a sequence is in progress. stby_ack is high only in deep standby and in freeze.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Interrupt-driven standby request |
| idle_expire | input | 1 | Idle-timeout standby request |
| mode_freeze | input | 1 | Mode for the request: 0 deep, 1 freeze |
| wait_limit | input | WAIT_W | Cycle limit on each handshake wait |
| save_done | input | 1 | Processor context saved |
| flush_done | input | 1 | Caches and translation buffers flushed |
| pwr_good | input | 1 | Domain supply is up |
| restore_done | input | 1 | Processor context restored |
| wake_irq | input | 1 | External wake interrupt |
| rtc_expire | input | 1 | Real-time-clock timer expiry |
| busy | output | 1 | Sequence in progress |
| stby_ack | output | 1 | Domain is in standby (deep or freeze) |
| err | output | 1 | A handshake wait timed out (sticky) |
| save_req | output | 1 | Request processor context save |
| flush_req | output | 1 | Request cache and translation flush |
| clk_stop | output | 1 | Stop the domain clocks |
| vlow | output | 1 | Request reduced retention voltage |
| pwr_en | output | 1 | Domain power switch enable |
| scan_stb | output | 1 | One scan shift per cycle while high |
| scan_dir | output | 1 | 0 shift to storage, 1 shift from storage |
| restore_req | output | 1 | Request processor context restore |
| last_mode | output | 1 | Mode of the last standby entered |
| wake_src | output | 1 | Source of the last wake: 0 irq, 1 rtc |

## Verification
Every output is decoded from the state register, so each result is due exactly one clock after the edge that samples its cause. For example, flush_req comes one cycle after save_done, stby_ack one cycle after pwr_good falls, and busy clears one cycle after restore_done or after a freeze wake. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, so every comparison lands one cycle after its stimulus. Scan transfers are measured by counting strobe cycles until the strobe drops. The timeout boundary is checked at both cycle L, where the sequence must still advance, and cycle L+1, where err must be high.

// File: rtl/stby_pkg.sv
// Shared types for the standby sequencer.
// Assumes: a single always-on clock domain for all users of this package.
package stby_pkg;
    typedef enum logic [3:0] {
        ST_RUN,
        ST_SAVE,
        ST_FLUSH,
        ST_CSTOP,
        ST_SCAN_OUT,
        ST_PWR_OFF,
        ST_SUSPEND,
        ST_PWR_ON,
        ST_SCAN_IN,
        ST_CSTART,
        ST_RESTORE,
        ST_FREEZE,
        ST_ERROR
    } seq_state_t;

    localparam logic SRC_IRQ = 1'b0;
    localparam logic SRC_RTC = 1'b1;
endpackage

// File: rtl/stby_wait_timer.sv
// Cycle counter for one handshake wait. It restarts at zero whenever the
// sequencer changes state and saturates at the programmed limit.
// Assumes: limit is held stable while a wait is in progress.
module stby_wait_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [WAIT_W-1:0] limit,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt_q;

    // Count cycles spent in the current state, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The wait has used its whole allowance on this cycle.
    assign expired = (cnt_q == limit);
endmodule

// File: rtl/stby_bit_counter.sv
// Shift counter for one scan transfer of CHAIN_LEN bits.
// Assumes: run stays high for the whole transfer and drops right after last.
module stby_bit_counter #(
    parameter int CHAIN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(CHAIN_LEN - 1);

    logic [CW-1:0] bit_q;

    // Advance once per shifted bit and rewind at the end of the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (!run || last) begin
            bit_q <= '0;
        end else begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // Flag the final shift of the chain.
    assign last = run && (bit_q == LAST_IDX);
endmodule

// File: rtl/stby_wake_latch.sv
// Holds a wake event seen during shutdown, standby or freeze, and records
// the source of the first such event of the episode.
// Assumes: clear is raised once the domain is on its way back up.
module stby_wake_latch
    import stby_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture_en,
    input  logic clear,
    input  logic wake_irq,
    input  logic rtc_expire,
    output logic pending,
    output logic src
);
    logic event_now;

    assign event_now = capture_en && (wake_irq || rtc_expire);

    // Pending flag: set by a wake event, dropped when restore has begun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (clear) begin
            pending <= 1'b0;
        end else if (event_now) begin
            pending <= 1'b1;
        end
    end

    // Source record: first event of the episode wins, irq breaks a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= SRC_IRQ;
        end else if (event_now && !pending) begin
            src <= wake_irq ? SRC_IRQ : SRC_RTC;
        end
    end
endmodule

// File: rtl/standby_seq.sv
// Standby sequencer for one power domain. Walks deep shutdown (save, flush,
// clock stop, scan out, power off), waits for a wake, and restores in the
// reverse order. A freeze mode only stops clocks and lowers the voltage.
// Assumes: all handshake inputs are synchronous to clk, and wait_limit is
// static during a sequence.
module standby_seq
    import stby_pkg::*;
#(
    parameter int CHAIN_LEN = 16,
    parameter int WAIT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic              idle_expire,
    input  logic              mode_freeze,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic              save_done,
    input  logic              flush_done,
    input  logic              pwr_good,
    input  logic              restore_done,
    input  logic              wake_irq,
    input  logic              rtc_expire,
    output logic              busy,
    output logic              stby_ack,
    output logic              err,
    output logic              save_req,
    output logic              flush_req,
    output logic              clk_stop,
    output logic              vlow,
    output logic              pwr_en,
    output logic              scan_stb,
    output logic              scan_dir,
    output logic              restore_req,
    output logic              last_mode,
    output logic              wake_src
);
    seq_state_t st_q, st_d;
    logic       wait_over;
    logic       scan_last;
    logic       scan_run;
    logic       wake_pend;
    logic       wake_any;
    logic       capture_en;
    logic       wake_clear;
    logic       start;

    assign start    = (st_q == ST_RUN) && (sw_req || idle_expire);
    assign scan_run = (st_q == ST_SCAN_OUT) || (st_q == ST_SCAN_IN);
    assign wake_any = wake_pend || wake_irq || rtc_expire;

    // Wake capture window: shutdown steps, deep standby and freeze.
    always_comb begin : capture_window
        unique case (st_q)
            ST_SAVE, ST_FLUSH, ST_CSTOP, ST_SCAN_OUT,
            ST_PWR_OFF, ST_SUSPEND, ST_FREEZE: capture_en = 1'b1;
            default:                           capture_en = 1'b0;
        endcase
    end

    assign wake_clear = (st_q == ST_PWR_ON) || (st_q == ST_RUN);

    stby_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st_d != st_q),
        .limit   (wait_limit),
        .expired (wait_over)
    );

    stby_bit_counter #(.CHAIN_LEN(CHAIN_LEN)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (scan_run),
        .last  (scan_last)
    );

    stby_wake_latch u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .clear      (wake_clear),
        .wake_irq   (wake_irq),
        .rtc_expire (rtc_expire),
        .pending    (wake_pend),
        .src        (wake_src)
    );

    // Next-state logic: each wait advances on its done input or times out.
    always_comb begin : next_state
        st_d = st_q;
        unique case (st_q)
            ST_RUN:      if (start) st_d = mode_freeze ? ST_FREEZE : ST_SAVE;
            ST_SAVE:     if (save_done)    st_d = ST_FLUSH;
                         else if (wait_over) st_d = ST_ERROR;
            ST_FLUSH:    if (flush_done)   st_d = ST_CSTOP;
                         else if (wait_over) st_d = ST_ERROR;
            ST_CSTOP:    st_d = ST_SCAN_OUT;
            ST_SCAN_OUT: if (scan_last)    st_d = ST_PWR_OFF;
            ST_PWR_OFF:  if (!pwr_good)    st_d = ST_SUSPEND;
                         else if (wait_over) st_d = ST_ERROR;
            ST_SUSPEND:  if (wake_any)     st_d = ST_PWR_ON;
            ST_PWR_ON:   if (pwr_good)     st_d = ST_SCAN_IN;
                         else if (wait_over) st_d = ST_ERROR;
            ST_SCAN_IN:  if (scan_last)    st_d = ST_CSTART;
            ST_CSTART:   st_d = ST_RESTORE;
            ST_RESTORE:  if (restore_done) st_d = ST_RUN;
                         else if (wait_over) st_d = ST_ERROR;
            ST_FREEZE:   if (wake_any)     st_d = ST_RUN;
            ST_ERROR:    st_d = ST_ERROR;
            default:     st_d = ST_ERROR;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // Mode status: remember which standby the last request chose.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_mode <= 1'b0;
        end else if (start) begin
            last_mode <= mode_freeze;
        end
    end

    // Output decode from the current state.
    always_comb begin : out_decode
        save_req    = (st_q == ST_SAVE);
        flush_req   = (st_q == ST_FLUSH);
        restore_req = (st_q == ST_RESTORE);
        scan_stb    = scan_run;
        scan_dir    = (st_q == ST_SCAN_IN);
        vlow        = (st_q == ST_FREEZE);
        stby_ack    = (st_q == ST_SUSPEND) || (st_q == ST_FREEZE);
        pwr_en      = !((st_q == ST_PWR_OFF) || (st_q == ST_SUSPEND));
        err         = (st_q == ST_ERROR);
        busy        = (st_q != ST_RUN);
        unique case (st_q)
            ST_CSTOP, ST_SCAN_OUT, ST_PWR_OFF, ST_SUSPEND,
            ST_PWR_ON, ST_SCAN_IN, ST_FREEZE, ST_ERROR: clk_stop = 1'b1;
            default:                                    clk_stop = 1'b0;
        endcase
    end
endmodule

// File: rtl/stby_seq_chk.sv
// Property checker for standby_seq, attached by bind below.
// Assumes: it sees the top-level ports of the sequencer only.
module stby_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_req,
    input logic idle_expire,
    input logic mode_freeze,
    input logic busy,
    input logic stby_ack,
    input logic err,
    input logic save_req,
    input logic flush_req,
    input logic clk_stop,
    input logic vlow,
    input logic pwr_en,
    input logic scan_stb,
    input logic wake_src
);
    assert_deep_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (sw_req || idle_expire) && !mode_freeze) |=> save_req);

    assert_freeze_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (sw_req || idle_expire) && mode_freeze) |=> vlow);

    assert_flush_after_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(save_req) |-> (flush_req || err));

    assert_clocks_off_unpowered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> clk_stop);

    assert_scan_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb |-> pwr_en);

    assert_suspend_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_ack && !vlow) |=> (stby_ack || pwr_en));

    assert_freeze_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vlow |-> (pwr_en && clk_stop && !scan_stb && !save_req));

    assert_src_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(wake_src));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_ack_in_sequence_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stby_ack |-> busy);
endmodule

bind standby_seq stby_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_req      (sw_req),
    .idle_expire (idle_expire),
    .mode_freeze (mode_freeze),
    .busy        (busy),
    .stby_ack    (stby_ack),
    .err         (err),
    .save_req    (save_req),
    .flush_req   (flush_req),
    .clk_stop    (clk_stop),
    .vlow        (vlow),
    .pwr_en      (pwr_en),
    .scan_stb    (scan_stb),
    .wake_src    (wake_src)
);

// File: tb/sim_standby_seq.sv
// Bench for standby_seq: a scenario table walked by one loop, then directed
// tests for reset, wake while idle, and the wait timeout boundary.
module sim_standby_seq;
    localparam int CHAIN_LEN = 16;
    localparam int WAIT_W    = 8;

    // Table entry bits: {freeze, by_idle, wake[1:0], early, exp_mode, exp_src}
    // wake: 0 irq, 1 rtc, 2 both in the same cycle.
    localparam logic [6:0] VEC [7] = '{
        7'b0000000, 7'b0101001, 7'b0010100, 7'b0101101,
        7'b1100010, 7'b1010010, 7'b1001011
    };

    logic clk = 1'b0;
    logic rst_n, sw_req, idle_expire, mode_freeze;
    logic [WAIT_W-1:0] wait_limit;
    logic save_done, flush_done, pwr_good, restore_done, wake_irq, rtc_expire;
    logic busy, stby_ack, err, save_req, flush_req, clk_stop, vlow, pwr_en;
    logic scan_stb, scan_dir, restore_req, last_mode, wake_src;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;

    always #2.5 clk = ~clk;

    standby_seq #(.CHAIN_LEN(CHAIN_LEN), .WAIT_W(WAIT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .idle_expire(idle_expire),
        .mode_freeze(mode_freeze), .wait_limit(wait_limit),
        .save_done(save_done), .flush_done(flush_done), .pwr_good(pwr_good),
        .restore_done(restore_done), .wake_irq(wake_irq), .rtc_expire(rtc_expire),
        .busy(busy), .stby_ack(stby_ack), .err(err), .save_req(save_req),
        .flush_req(flush_req), .clk_stop(clk_stop), .vlow(vlow), .pwr_en(pwr_en),
        .scan_stb(scan_stb), .scan_dir(scan_dir), .restore_req(restore_req),
        .last_mode(last_mode), .wake_src(wake_src)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_wake(input logic [1:0] wk);
        wake_irq   = (wk != 2'd1);
        rtc_expire = (wk != 2'd0);
    endtask

    task automatic clr_wake();
        wake_irq   = 1'b0;
        rtc_expire = 1'b0;
    endtask

    // Count strobe cycles of one transfer and check their direction (R4).
    task automatic count_scan(input logic dir);
        int n = 0;
        int bad = 0;
        while (scan_stb && n < 1000) begin
            if (scan_dir != dir) bad++;
            n++;
            step();
        end
        chk(n == CHAIN_LEN, "R4 scan length", n, CHAIN_LEN);
        chk(bad == 0, "R4 scan direction", bad, 0);
    endtask

    task automatic run_scn(input logic [6:0] v);
        logic frz, early;
        logic [1:0] wk;
        frz = v[6];
        wk = v[4:3];
        early = v[2];
        mode_freeze = frz;
        if (v[5]) idle_expire = 1'b1; else sw_req = 1'b1;
        step();
        sw_req = 1'b0;
        idle_expire = 1'b0;
        if (frz) begin
            chk(vlow && clk_stop && stby_ack && pwr_en, "R8 freeze entry", {vlow, clk_stop, stby_ack, pwr_en}, 15);
            chk(!save_req && !scan_stb && !flush_req, "R8 no save work", {save_req, scan_stb, flush_req}, 0);
            step();
            chk(vlow && busy, "R8 freeze held", {vlow, busy}, 3);
            set_wake(wk);
            step();
            clr_wake();
            chk(!busy && !clk_stop && !vlow, "R8 fast resume", {busy, clk_stop, vlow}, 0);
        end else begin
            chk(save_req && !clk_stop && busy, "R2 save request", {save_req, clk_stop, busy}, 5);
            if (early) begin
                set_wake(wk);
                step();
                clr_wake();
                chk(save_req && pwr_en, "R9 shutdown continues", {save_req, pwr_en}, 3);
            end
            save_done = 1'b1;
            step();
            save_done = 1'b0;
            chk(flush_req && !save_req, "R3 flush after save", {flush_req, save_req}, 2);
            flush_done = 1'b1;
            step();
            flush_done = 1'b0;
            chk(clk_stop && !flush_req && !scan_stb && pwr_en, "R3 clock stop", {clk_stop, flush_req, scan_stb, pwr_en}, 9);
            step();
            count_scan(1'b0);
            chk(!pwr_en && !stby_ack, "R5 power off", {pwr_en, stby_ack}, 0);
            pwr_good = 1'b0;
            step();
            chk(stby_ack && !pwr_en, "R5 standby ack", {stby_ack, pwr_en}, 2);
            if (!early) begin
                sw_req = 1'b1;
                step();
                sw_req = 1'b0;
                chk(stby_ack && !pwr_en, "R6 request ignored", {stby_ack, pwr_en}, 2);
                step();
                chk(stby_ack, "R6 still waiting", stby_ack, 1);
                set_wake(wk);
                step();
                clr_wake();
                chk(pwr_en && !stby_ack && clk_stop, "R6 power returns", {pwr_en, stby_ack, clk_stop}, 5);
            end else begin
                step();
                chk(pwr_en && !stby_ack && clk_stop, "R9 held wake restores", {pwr_en, stby_ack, clk_stop}, 5);
            end
            step();
            chk(pwr_en && !scan_stb, "R7 waits for power good", {pwr_en, scan_stb}, 2);
            pwr_good = 1'b1;
            step();
            count_scan(1'b1);
            chk(!clk_stop && !restore_req, "R7 clock restart", {clk_stop, restore_req}, 0);
            step();
            chk(restore_req && !clk_stop, "R7 restore request", {restore_req, clk_stop}, 2);
            restore_done = 1'b1;
            step();
            restore_done = 1'b0;
            chk(!busy && !restore_req && !stby_ack, "R12 back to idle", {busy, restore_req, stby_ack}, 0);
        end
        chk(last_mode == v[1], "R2 last mode", last_mode, v[1]);
        chk(wake_src == v[0], "R10 wake source", wake_src, v[0]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sw_req = 1'b0; idle_expire = 1'b0; mode_freeze = 1'b0;
        save_done = 1'b0; flush_done = 1'b0; restore_done = 1'b0;
        pwr_good = 1'b1; clr_wake();
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done_run) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_limit = 8'd200;
        do_reset();
        // R1 reset state
        chk(!busy && !stby_ack && !err && !save_req && !flush_req && !restore_req,
            "R1 reset handshakes", {busy, stby_ack, err, save_req, flush_req, restore_req}, 0);
        chk(pwr_en && !clk_stop && !vlow && !scan_stb, "R1 reset power", {pwr_en, clk_stop, vlow, scan_stb}, 8);
        chk(!last_mode && !wake_src, "R1 reset status", {last_mode, wake_src}, 0);

        for (int i = 0; i < 7; i++) begin
            run_scn(VEC[i]);
            step();
        end

        // R10: wake inputs while idle leave the recorded source alone (last was rtc).
        wake_irq = 1'b1;
        step();
        wake_irq = 1'b0;
        chk(!busy && wake_src == 1'b1 && pwr_en && !clk_stop, "R10 idle wake ignored", {busy, wake_src}, 1);

        // R11: done on cycle L still advances; no done errors after L+1 cycles.
        wait_limit = 8'd3;
        mode_freeze = 1'b0;
        sw_req = 1'b1;
        step();
        sw_req = 1'b0;
        repeat (3) step();
        chk(save_req && !err, "R11 no error at limit", {save_req, err}, 2);
        save_done = 1'b1;
        step();
        save_done = 1'b0;
        chk(flush_req && !err, "R11 done at limit advances", {flush_req, err}, 2);
        repeat (3) step();
        chk(flush_req && !err, "R11 still waiting", {flush_req, err}, 2);
        step();
        chk(err && busy && !flush_req, "R11 timeout error", {err, busy, flush_req}, 6);
        sw_req = 1'b1;
        wake_irq = 1'b1;
        flush_done = 1'b1;
        step();
        sw_req = 1'b0;
        wake_irq = 1'b0;
        flush_done = 1'b0;
        step();
        chk(err, "R11 error sticky", err, 1);

        wait_limit = 8'd200;
        do_reset();
        chk(!err && !busy && pwr_en, "R1 reset clears error", {err, busy, pwr_en}, 1);

        done_run = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule